// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block turns a list of segment descriptors held in memory into a stream of (address, length, last) segments for a hash datapath. A descriptor is 8 bytes long. Its first 32-bit word carries the segment length and a final-entry flag, and its second word carries the segment address. The block reads both words through a request/response memory port that has one read outstanding at a time. It decodes the fields and presents each segment on a valid/ready output. It does not fetch the data bytes, and it does not hash anything.

A walk begins with a `start` pulse while the block is idle. In list mode, `list_base` gives the location of the first descriptor. In direct mode, a single segment is formed from `direct_addr` and `direct_len` and no memory is read. The walk ends in one of two ways: after the entry whose final flag is set, or after `MAX_ENTRIES` entries that carry no final flag. The second case is an error. In both cases `done` pulses once, and `err` tells the two cases apart.

The segment output follows the usual valid/ready rules. `seg_valid` stays high and the segment fields stay unchanged until the cycle in which `seg_ready` is high, and `seg_valid` does not depend on `seg_ready` within a cycle. The memory request follows the same rules. A response is accepted only while a read is pending.

Top module: `sg_list_walker`

## Requirements
- R1: After reset `busy`, `done`, `err`, `seg_valid` and `mem_req_valid` are all low.
- R2: Descriptor i sits at `list_base + 8*i`. The block reads the length word at offset 0 first and then the address word at offset 4, with at most one read outstanding, and it never requests a read while a segment is being offered.
- R3: The segment length is bits 27:0 of the length word. Bits 30:28 are ignored. Bit 31 is the final flag and appears on `seg_last`.
- R4: The segment address is bits 30:0 of the address word, and bit 31 is dropped.
- R5: After the segment whose final flag is set has been accepted, no further memory read is issued.
- R6: If `MAX_ENTRIES` entries are accepted with no final flag among them, the walk stops without reading entry `MAX_ENTRIES`, and `err` is high together with `done`.
- R7: In direct mode (`sg_mode` = 0 at start), exactly one segment is emitted. It carries `direct_addr`, `direct_len` and `seg_last` = 1, and no memory read is made.
- R8: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr`, `seg_len` and `seg_last` keep their values. Likewise, `mem_req_addr` and `mem_req_valid` hold until `mem_req_ready` is high.
- R9: `done` is high for exactly one cycle, and that cycle directly follows the acceptance of the walk's last segment. `err` is never high without `done`. When a walk ends on its final flag, `err` is low.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the walk in progress or on its reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk when idle |
| sg_mode | input | 1 | 1: walk a descriptor list; 0: direct single segment |
| list_base | input | ADDR_W | Byte address of descriptor 0 |
| direct_addr | input | 31 | Segment address in direct mode |
| direct_len | input | 28 | Segment length in direct mode |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the 32-bit word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data, little-endian word |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted downstream |
| seg_addr | output | 31 | Segment byte address |
| seg_len | output | 28 | Segment byte length |
| seg_last | output | 1 | Final flag of the segment |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Walk aborted at the entry limit, valid with done |

## Verification
The assertions assume that the memory side returns exactly one response for each accepted request, that the response comes at least one cycle after acceptance, and that no response arrives while no read is pending. They also assume that `list_base` is word aligned. The bench's memory model meets these assumptions: for each accepted request it schedules one response after one to three cycles. It draws ready signals at random, which exercises stalls on both handshakes. It places well-formed descriptors at aligned bases, with one extra entry beyond the end of each list so that any over-read shows up.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 28;
  localparam int SEG_AW     = 31;
  localparam int FLAG_BIT   = 31;
  localparam int WORD_BYTES = 4;
  localparam int DESC_SHIFT = 3;   // 8-byte descriptors

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LEN,
    ST_WAIT_LEN,
    ST_REQ_ADR,
    ST_WAIT_ADR,
    ST_EMIT,
    ST_DONE
  } sgw_state_e;
endpackage

// File: rtl/sgw_desc_field.sv
module sgw_desc_field
  import sgw_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [LEN_W-1:0]  len_f,
  output logic              flag_f,
  output logic [SEG_AW-1:0] addr_f
);
  // Bits 30:28 of the length word carry nothing for this block.
  logic unused_rsvd;
  assign unused_rsvd = ^word[FLAG_BIT-1:LEN_W];

  assign len_f  = word[LEN_W-1:0];
  assign flag_f = word[FLAG_BIT];
  assign addr_f = word[SEG_AW-1:0];
endmodule

// File: rtl/sgw_cursor.sv
module sgw_cursor
  import sgw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 16,
  localparam int IDX_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              word_sel,   // 0: length word, 1: address word
  output logic [ADDR_W-1:0] word_addr,
  output logic              at_limit
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] entry_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= base;
      idx_q  <= '0;
    end else if (advance) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign entry_off = ADDR_W'(idx_q) << DESC_SHIFT;
  assign word_addr = base_q + entry_off + (word_sel ? ADDR_W'(WORD_BYTES) : '0);
  assign at_limit  = (idx_q == IDX_W'(MAX_ENTRIES - 1));
endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sg_mode,
  input  logic [ADDR_W-1:0] list_base,
  input  logic [SEG_AW-1:0] direct_addr,
  input  logic [LEN_W-1:0]  direct_len,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [SEG_AW-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last,
  output logic              busy,
  output logic              done,
  output logic              err
);
  sgw_state_e        state_q;
  logic              list_q;
  logic              abort_q;
  logic [LEN_W-1:0]  len_q;
  logic [SEG_AW-1:0] addr_q;
  logic              last_q;

  logic              accept_start;
  logic              seg_fire;
  logic              at_limit;
  logic [LEN_W-1:0]  dec_len;
  logic              dec_flag;
  logic [SEG_AW-1:0] dec_addr;

  assign accept_start = start && (state_q == ST_IDLE);
  assign seg_fire     = (state_q == ST_EMIT) && seg_ready;

  sgw_desc_field u_field (
    .word   (mem_rsp_data),
    .len_f  (dec_len),
    .flag_f (dec_flag),
    .addr_f (dec_addr)
  );

  sgw_cursor #(
    .ADDR_W      (ADDR_W),
    .MAX_ENTRIES (MAX_ENTRIES)
  ) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_start),
    .base      (list_base),
    .advance   (seg_fire && list_q),
    .word_sel  (state_q == ST_REQ_ADR),
    .word_addr (mem_req_addr),
    .at_limit  (at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      list_q  <= 1'b0;
      abort_q <= 1'b0;
      len_q   <= '0;
      addr_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            list_q  <= sg_mode;
            abort_q <= 1'b0;
            if (sg_mode) begin
              state_q <= ST_REQ_LEN;
            end else begin
              addr_q  <= direct_addr;
              len_q   <= direct_len;
              last_q  <= 1'b1;
              state_q <= ST_EMIT;
            end
          end
        end
        ST_REQ_LEN:  if (mem_req_ready) state_q <= ST_WAIT_LEN;
        ST_WAIT_LEN: begin
          if (mem_rsp_valid) begin
            len_q   <= dec_len;
            last_q  <= dec_flag;
            state_q <= ST_REQ_ADR;
          end
        end
        ST_REQ_ADR:  if (mem_req_ready) state_q <= ST_WAIT_ADR;
        ST_WAIT_ADR: begin
          if (mem_rsp_valid) begin
            addr_q  <= dec_addr;
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (seg_ready) begin
            if (!list_q || last_q) begin
              state_q <= ST_DONE;
            end else if (at_limit) begin
              abort_q <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_REQ_LEN;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == ST_REQ_LEN) || (state_q == ST_REQ_ADR);
  assign seg_valid     = (state_q == ST_EMIT);
  assign seg_addr      = addr_q;
  assign seg_len       = len_q;
  assign seg_last      = last_q;
  assign busy          = (state_q != ST_IDLE);
  assign done          = (state_q == ST_DONE);
  assign err           = done && abort_q;
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [SEG_AW-1:0] seg_addr,
  input logic [LEN_W-1:0]  seg_len,
  input logic              seg_last,
  input logic              busy,
  input logic              done,
  input logic              err
);
  p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && seg_valid));

  p_last_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_ready && seg_last |=> !mem_req_valid && !seg_valid);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_done_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(seg_valid && seg_ready));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !seg_valid && !done);
endmodule

bind sg_list_walker sgw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .seg_valid     (seg_valid),
  .seg_ready     (seg_ready),
  .seg_addr      (seg_addr),
  .seg_len       (seg_len),
  .seg_last      (seg_last),
  .busy          (busy),
  .done          (done),
  .err           (err)
);

// File: tb/sg_list_walker_test.sv
module sg_list_walker_test;
  localparam int MAXE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sg_mode = 1'b0;
  logic [31:0] list_base = '0;
  logic [30:0] direct_addr = '0;
  logic [27:0] direct_len = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [30:0] seg_addr;
  logic [27:0] seg_len;
  logic        seg_last;
  logic        busy, done, err;

  always #2 clk = ~clk;   // 250 MHz

  sg_list_walker #(.ADDR_W(32), .MAX_ENTRIES(MAXE)) uut (.*);

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [31:0] mem [int unsigned];
  logic [31:0] exp_rd[$];
  logic [59:0] exp_seg[$];
  bit          exp_err = 0;
  bit          exp_done = 0;
  bit          walk_done = 0;
  bit          run_mon = 0;
  bit          rsp_pend = 0;
  int          rsp_cnt = 0;
  logic [31:0] rsp_word = '0;
  bit          prev_stall = 0;
  logic [59:0] prev_seg = '0;
  int          stall_pct = 25;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic put_desc(input logic [31:0] base, input int i,
                          input logic [31:0] lw, input logic [31:0] aw, input bit expect_it);
    logic [31:0] a;
    a = base + 32'(i * 8);
    mem[a] = lw;
    mem[a + 4] = aw;
    if (expect_it) begin
      exp_rd.push_back(a);
      exp_rd.push_back(a + 4);
      exp_seg.push_back({aw[30:0], lw[27:0], lw[31]});
    end
  endtask

  // Reference model: compares every handshake and done/err on every clock.
  always @(negedge clk) begin
    cycles++;
    mem_rsp_valid = 1'b0;
    if (rsp_pend) begin
      if (rsp_cnt <= 1) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rsp_word;
        rsp_pend = 0;
      end else rsp_cnt--;
    end
    mem_req_ready = ($urandom % 100) >= 30;
    seg_ready     = ($urandom % 100) >= stall_pct;
    #1;
    if (run_mon) begin
      if (done || exp_done) chk(done == exp_done, "R9", "done timing", 64'(done), 64'(exp_done));
      if (done) begin
        walk_done = 1;
        chk(err == exp_err, "R6", "err at done", 64'(err), 64'(exp_err));
      end
      exp_done = 0;
      if (prev_stall) begin
        chk(seg_valid && {seg_addr, seg_len, seg_last} == prev_seg, "R8", "stalled segment",
            64'({seg_valid, seg_addr, seg_len, seg_last}), 64'({1'b1, prev_seg}));
      end
      prev_stall = seg_valid && !seg_ready;
      prev_seg   = {seg_addr, seg_len, seg_last};
      if (mem_req_valid && mem_req_ready) begin
        if (exp_rd.size() == 0) begin
          chk(0, "R5", "unexpected read", 64'(mem_req_addr), 64'hFFFF_FFFF);
        end else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          chk(mem_req_addr == e, "R2", "read address", 64'(mem_req_addr), 64'(e));
        end
        rsp_word = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'hDEAD_BEEF;
        rsp_pend = 1;
        rsp_cnt  = 1 + int'($urandom % 3);
      end
      if (seg_valid && seg_ready) begin
        if (exp_seg.size() == 0) begin
          chk(0, "R5", "unexpected segment", 64'({seg_addr, seg_len, seg_last}), 64'h0);
        end else begin
          logic [59:0] s;
          s = exp_seg.pop_front();
          chk(seg_len == s[28:1], "R3", "segment length", 64'(seg_len), 64'(s[28:1]));
          chk(seg_last == s[0], "R3", "final flag", 64'(seg_last), 64'(s[0]));
          chk(seg_addr == s[59:29], "R4", "segment address", 64'(seg_addr), 64'(s[59:29]));
          if (exp_seg.size() == 0) exp_done = 1;
        end
      end
    end
  end

  task automatic walk(input bit sg, input logic [31:0] base, input logic [30:0] da,
                      input logic [27:0] dl, input bit e_err, input bit poke, input string req);
    walk_done = 0;
    exp_err = e_err;
    @(negedge clk);
    start = 1'b1; sg_mode = sg; list_base = base; direct_addr = da; direct_len = dl;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R10", "busy before poke", 64'(busy), 64'h1);
      start = 1'b1; sg_mode = 1'b0; list_base = 32'h0000_1000;
      direct_addr = 31'h0BAD_0000; direct_len = 28'h0BAD;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 3000 && !walk_done; k++) @(negedge clk);
    chk(walk_done, req, "walk finished", 64'(walk_done), 64'h1);
    chk(exp_rd.size() == 0 && exp_seg.size() == 0, req, "all reads and segments seen",
        64'(exp_rd.size() + exp_seg.size()), 64'h0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, req, "idle after walk", 64'(busy), 64'h0);
    exp_rd.delete();
    exp_seg.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, seg_valid, mem_req_valid} == 5'b0, "R1", "reset outputs",
        64'({busy, done, err, seg_valid, mem_req_valid}), 64'h0);
    run_mon = 1;

    // R2 R3 R4: three entries, reserved length bits and address bit 31 set, spare entry after
    put_desc(32'h0000_1000, 0, 32'h7000_0040, 32'h8000_2000, 1);
    put_desc(32'h0000_1000, 1, 32'h0ABC_DEF1, 32'hFFFF_FFFF, 1);
    put_desc(32'h0000_1000, 2, 32'h8000_0010, 32'h1234_5678, 1);
    put_desc(32'h0000_1000, 3, 32'h0000_0099, 32'h0000_0999, 0);
    walk(1, 32'h0000_1000, '0, '0, 0, 0, "R5");

    // R7: direct mode
    exp_seg.push_back({31'h5555_0000, 28'hFFF_FFFF, 1'b1});
    walk(0, 32'h0000_1000, 31'h5555_0000, 28'hFFF_FFFF, 0, 0, "R7");

    // R6: no final flag within the limit
    for (int i = 0; i < MAXE; i++)
      put_desc(32'h0000_4000, i, 32'h0000_0100 + 32'(i), 32'h0001_0000 + 32'(i * 16), 1);
    put_desc(32'h0000_4000, MAXE, 32'h8000_0001, 32'h0000_0001, 0);
    walk(1, 32'h0000_4000, '0, '0, 1, 0, "R6");

    // R6 boundary: final flag on the last allowed entry, no error
    for (int i = 0; i < MAXE; i++)
      put_desc(32'h0000_5000, i, (i == MAXE - 1 ? 32'h8000_0000 : 32'h0) | 32'(i + 1),
               32'h0002_0000 + 32'(i), 1);
    walk(1, 32'h0000_5000, '0, '0, 0, 0, "R6");

    // R3: single entry, zero length, final
    put_desc(32'h0000_0008, 0, 32'h8000_0000, 32'h0000_0000, 1);
    put_desc(32'h0000_0008, 1, 32'h0000_0005, 32'h0000_0005, 0);
    walk(1, 32'h0000_0008, '0, '0, 0, 0, "R3");

    // R10: start pulse mid-walk, heavy back-pressure (R8)
    stall_pct = 70;
    put_desc(32'h0000_6000, 0, 32'h0000_0020, 32'h0000_7000, 1);
    put_desc(32'h0000_6000, 1, 32'h0000_0030, 32'h0000_7100, 1);
    put_desc(32'h0000_6000, 2, 32'h8000_0040, 32'h0000_7200, 1);
    walk(1, 32'h0000_6000, '0, '0, 0, 1, "R10");

    // R8: direct mode under stalls
    exp_seg.push_back({31'h0000_0004, 28'h000_0001, 1'b1});
    walk(0, 32'h0, 31'h0000_0004, 28'h000_0001, 0, 0, "R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule